// File: doc/BRIEF.md
# Coefficient and Control Register Port (AXI4-Lite Slave)

This block is the configuration side of a filter accelerator. A host on an AXI4-Lite bus reaches two things through it: a small coefficient store and three control words (a run/control word, a sample count and a tap count). The write address and write data channels are tracked by two independent handshake machines. Either channel may arrive first. The early one is parked in its own holding register until its partner is captured. One write strobe then updates either the coefficient store or the selected control word.

Reads return a control word or a coefficient. The coefficient store is synchronous and delivers data one clock after it sees an address. While the read channel is idle, the store is addressed straight from the incoming read address. As a result, data is ready in the cycle after the address handshake. After that, the store is addressed from the held copy of the address.

Top module: `coef_regport`

## Requirements
- R1: After a synchronous reset, awready, wready and arready are 1, and bvalid and rvalid are 0. All control words read back as 0.
- R2: When the write address is accepted first, awready stays 0 and wready stays 1 until the data arrives. The held address is used even if awaddr changes in the meantime.
- R3: When the write data is accepted first, wready stays 0 and awready stays 1 until the address arrives. The held data is written even if wdata changes in the meantime.
- R4: After a channel's own handshake, awready and wready each stay 0 until the write response is accepted. Both are 1 again in the cycle after bvalid&&bready.
- R5: bvalid rises exactly two clocks after the later of the two write handshakes, with bresp = 2'b00. It stays high until bready.
- R6: Control words sit at byte offset 0x00 (control), 0x10 (sample count) and 0x14 (tap count). Each is matched exactly and stores and returns all 32 bits.
- R7: Writes to addresses below 0x80 that are not one of the three offsets change nothing. Reads from such addresses return 0.
- R8: Addresses of 0x80 and above select the coefficient store. Byte address 0x80+4k selects word k, for k below the store depth (16).
- R9: arready is 1 only while no read is outstanding. rvalid rises one clock after the address handshake, with rresp = 2'b00, and stays high with unchanged rdata until rready.
- R10: The returned coefficient belongs to the address taken at the handshake, whether rready is already high in that cycle or arrives later. Changing araddr after the handshake has no effect.
- R11: A read issued right after a write response returns the newly written coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | 12 | Write byte address |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | 32 | Write data |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code (always OKAY) |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | 12 | Read byte address |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response code (always OKAY) |

## Verification
The hardest case to reach is a write whose two channels are captured in different cycles while the idle bus lines change underneath. The held copy must win over the live input. The bench sweeps every coefficient word and rotates among address-first, data-first and same-cycle orderings, with varying gaps between the two handshakes. It scrambles awaddr and wdata during each gap and varies the bready delay. Reads mix rready already high at the address handshake with rready arriving several cycles later, while araddr is scrambled. This exercises both the bypass path and the held-address path of the synchronous store.

// File: rtl/regport_pkg.sv
package regport_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_TAPS  = 12'h014;
    localparam logic [ADDR_W-1:0] MEM_BASE  = 12'h080;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [1:0] {
        HS_READY,
        HS_HOLD,
        HS_DONE,
        HS_RESP
    } hs_state_e;

    typedef enum logic {
        RD_ADDR,
        RD_VALID
    } rd_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] count;
        logic [DATA_W-1:0] taps;
    } ctl_regs_t;

    function automatic logic in_mem(input logic [ADDR_W-1:0] a);
        return a >= MEM_BASE;
    endfunction

endpackage

// File: rtl/chan_hold_fsm.sv
module chan_hold_fsm
    import regport_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid,
    input  logic [W-1:0] din,
    input  hs_state_e    partner_st,
    input  logic         bready,
    output logic         ready,
    output hs_state_e    state,
    output logic [W-1:0] held
);

    assign ready = (state == HS_READY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_READY;
            held  <= '0;
        end else begin
            unique case (state)
                HS_READY: if (valid) begin
                    state <= HS_HOLD;
                    held  <= din;
                end
                HS_HOLD:  if (partner_st == HS_HOLD) state <= HS_DONE;
                HS_DONE:  state <= HS_RESP;
                HS_RESP:  if (bready) state <= HS_READY;
                default:  state <= HS_READY;
            endcase
        end
    end

    // R4: after its own handshake the channel refuses more until the response is taken
    p_no_reaccept_r4: assert property (@(posedge clk) disable iff (rst)
        (valid && ready) |=> !ready);

    // R2 / R3: the parked item does not move while waiting for the partner
    p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (state == HS_HOLD) |=> $stable(held));

endmodule

// File: rtl/rd_chan_fsm.sv
module rd_chan_fsm
    import regport_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arvalid,
    input  logic [AW-1:0] araddr,
    input  logic          rready,
    output logic          arready,
    output logic          rvalid,
    output rd_state_e     state,
    output logic [AW-1:0] held
);

    assign arready = (state == RD_ADDR);
    assign rvalid  = (state == RD_VALID);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RD_ADDR;
            held  <= '0;
        end else begin
            unique case (state)
                RD_ADDR:  if (arvalid) begin
                    state <= RD_VALID;
                    held  <= araddr;
                end
                RD_VALID: if (rready) state <= RD_ADDR;
                default:  state <= RD_ADDR;
            endcase
        end
    end

    // R9: data is offered the clock after the address is taken
    p_ar_to_rvalid_r9: assert property (@(posedge clk) disable iff (rst)
        (arvalid && arready) |=> rvalid);

    // R9 / R10: an unaccepted read keeps its address and stays valid
    p_rvalid_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rvalid && !rready) |=> (rvalid && $stable(held)));

endmodule

// File: rtl/coef_store.sv
module coef_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    wdat,
    input  logic [IDX_W-1:0] ridx,
    output logic [DW-1:0]    rdat
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdat <= '0;
        end else begin
            if (we) mem[widx] <= wdat;
            rdat <= mem[ridx];
        end
    end

endmodule

// File: rtl/coef_regport.sv
module coef_regport
    import regport_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          awvalid,
    output logic          awready,
    input  logic [AW-1:0] awaddr,
    input  logic          wvalid,
    output logic          wready,
    input  logic [DW-1:0] wdata,
    output logic          bvalid,
    input  logic          bready,
    output logic [1:0]    bresp,
    input  logic          arvalid,
    output logic          arready,
    input  logic [AW-1:0] araddr,
    output logic          rvalid,
    input  logic          rready,
    output logic [DW-1:0] rdata,
    output logic [1:0]    rresp
);

    localparam int IDX_W = $clog2(DEPTH);

    hs_state_e     aw_st, w_st;
    rd_state_e     rd_st;
    logic [AW-1:0] aw_q, ar_q;
    logic [DW-1:0] w_q, mem_q;
    logic          wr_en;
    logic [IDX_W-1:0] rd_idx;
    ctl_regs_t     regs;

    chan_hold_fsm #(.W(AW)) u_aw (
        .clk(clk), .rst(rst), .valid(awvalid), .din(awaddr),
        .partner_st(w_st), .bready(bready),
        .ready(awready), .state(aw_st), .held(aw_q)
    );

    chan_hold_fsm #(.W(DW)) u_w (
        .clk(clk), .rst(rst), .valid(wvalid), .din(wdata),
        .partner_st(aw_st), .bready(bready),
        .ready(wready), .state(w_st), .held(w_q)
    );

    rd_chan_fsm #(.AW(AW)) u_rd (
        .clk(clk), .rst(rst), .arvalid(arvalid), .araddr(araddr),
        .rready(rready), .arready(arready), .rvalid(rvalid),
        .state(rd_st), .held(ar_q)
    );

    assign wr_en  = (aw_st == HS_DONE);
    assign bvalid = (aw_st == HS_RESP);
    assign bresp  = RESP_OKAY;
    assign rresp  = RESP_OKAY;

    // idle read channel feeds the live address so data is ready next cycle
    assign rd_idx = (rd_st == RD_ADDR) ? araddr[2 +: IDX_W] : ar_q[2 +: IDX_W];

    coef_store #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst(rst),
        .we(wr_en && in_mem(aw_q)), .widx(aw_q[2 +: IDX_W]), .wdat(w_q),
        .ridx(rd_idx), .rdat(mem_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else if (wr_en && !in_mem(aw_q)) begin
            case (aw_q)
                OFF_CTRL:  regs.ctrl  <= w_q;
                OFF_COUNT: regs.count <= w_q;
                OFF_TAPS:  regs.taps  <= w_q;
                default: ;
            endcase
        end
    end

    always_comb begin
        if (in_mem(ar_q)) begin
            rdata = mem_q;
        end else begin
            case (ar_q)
                OFF_CTRL:  rdata = regs.ctrl;
                OFF_COUNT: rdata = regs.count;
                OFF_TAPS:  rdata = regs.taps;
                default:   rdata = '0;
            endcase
        end
    end

    // R5: the write strobe lasts exactly one cycle
    p_we_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R5: a pending response is not dropped
    p_bvalid_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (bvalid && !bready) |=> bvalid);

    // R4: no new write address while a response is outstanding
    p_busy_no_aw_r4: assert property (@(posedge clk) disable iff (rst)
        bvalid |-> (!awready && !wready));

endmodule

// File: tb/coef_regport_bench.sv
module coef_regport_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [11:0] awaddr = 0, araddr = 0;
    logic [31:0] wdata = 0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    coef_regport u_coef_regport (
        .clk(clk), .rst(rst),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
        .wvalid(wvalid), .wready(wready), .wdata(wdata),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .arvalid(arvalid), .arready(arready), .araddr(araddr),
        .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] pat(input int k);
        return 32'hC0DE0000 ^ (k * 32'h01030507);
    endfunction

    // mode 0: address first, 1: data first, 2: same cycle
    task automatic do_write(input int mode, input logic [11:0] a, input logic [31:0] d,
                            input int gap, input int bdly);
        @(negedge clk);
        if (mode != 1) begin awvalid = 1; awaddr = a; end
        if (mode != 0) begin wvalid = 1; wdata = d; end
        @(negedge clk);
        awvalid = 0; wvalid = 0; awaddr = 12'hFFF; wdata = 32'hDEADBEEF;
        if (mode == 0) begin
            for (int g = 0; g < gap; g++) begin
                check(!awready && wready, "R2 parked address", {awready, wready}, 2'b01);
                @(negedge clk);
            end
            check(!awready && wready, "R2 parked address", {awready, wready}, 2'b01);
            wvalid = 1; wdata = d;
            @(negedge clk);
            wvalid = 0; wdata = 32'hDEADBEEF;
        end else if (mode == 1) begin
            for (int g = 0; g < gap; g++) begin
                check(awready && !wready, "R3 parked data", {awready, wready}, 2'b10);
                @(negedge clk);
            end
            check(awready && !wready, "R3 parked data", {awready, wready}, 2'b10);
            awvalid = 1; awaddr = a;
            @(negedge clk);
            awvalid = 0; awaddr = 12'hFFF;
        end
        check(!bvalid, "R5 bvalid early", bvalid, 0);
        @(negedge clk);
        check(!bvalid && !awready && !wready, "R4 busy channels", {bvalid, awready, wready}, 0);
        @(negedge clk);
        check(bvalid && bresp == 2'b00, "R5 bvalid timing", {bvalid, bresp}, 3'b100);
        for (int b = 0; b < bdly; b++) begin
            @(negedge clk);
            check(bvalid && !awready, "R5 bvalid hold", {bvalid, awready}, 2'b10);
        end
        bready = 1;
        @(negedge clk);
        bready = 0;
        check(!bvalid && awready && wready, "R4 channels reopen", {bvalid, awready, wready}, 3'b011);
    endtask

    task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input int rdly, input string req);
        @(negedge clk);
        arvalid = 1; araddr = a; rready = (rdly == 0);
        @(negedge clk);
        arvalid = 0; araddr = 12'hFFF;
        check(rvalid && rresp == 2'b00, "R9 rvalid after handshake", {rvalid, rresp}, 3'b100);
        check(rdata == exp, req, rdata, exp);
        if (rdly == 0) begin
            @(negedge clk);
            rready = 0;
        end else begin
            for (int r = 0; r < rdly; r++) begin
                @(negedge clk);
                check(rvalid && !arready && rdata == exp, "R9 read hold", rdata, exp);
            end
            rready = 1;
            @(negedge clk);
            rready = 0;
        end
        check(!rvalid && arready, "R9 read channel free", {rvalid, arready}, 2'b01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        check(awready && wready && arready && !bvalid && !rvalid, "R1 reset handshake state",
              {awready, wready, arready, bvalid, rvalid}, 5'b11100);
        do_read(12'h000, 32'h0, 0, "R1 control reset value");
        do_read(12'h010, 32'h0, 1, "R1 count reset value");
        do_read(12'h014, 32'h0, 0, "R1 taps reset value");

        // R8 coefficient sweep with all write orderings
        for (int k = 0; k < 16; k++)
            do_write(k % 3, 12'h080 + 12'(4 * k), pat(k), k % 4, k % 3);
        for (int k = 0; k < 16; k++)
            do_read(12'h080 + 12'(4 * k), pat(k), k % 3, "R8 R10 coefficient readback");

        // R6 control words
        do_write(0, 12'h000, 32'h0000_0001, 2, 0);
        do_write(1, 12'h010, 32'h0000_012C, 1, 2);
        do_write(2, 12'h014, 32'hFFFF_000B, 0, 1);
        do_read(12'h000, 32'h0000_0001, 0, "R6 control word");
        do_read(12'h010, 32'h0000_012C, 2, "R6 count word");
        do_read(12'h014, 32'hFFFF_000B, 1, "R6 taps word");

        // R7 unlisted low offsets
        do_write(2, 12'h004, 32'h1111_1111, 0, 0);
        do_write(0, 12'h018, 32'h2222_2222, 1, 0);
        do_write(1, 12'h07C, 32'h3333_3333, 0, 1);
        do_read(12'h004, 32'h0, 0, "R7 unlisted reads zero");
        do_read(12'h018, 32'h0, 1, "R7 unlisted reads zero");
        do_read(12'h07C, 32'h0, 0, "R7 unlisted reads zero");
        do_read(12'h000, 32'h0000_0001, 0, "R7 control untouched");
        do_read(12'h010, 32'h0000_012C, 0, "R7 count untouched");
        do_read(12'h014, 32'hFFFF_000B, 0, "R7 taps untouched");
        do_read(12'h080, pat(0), 0, "R7 coefficient untouched");

        // R11 write then immediate read
        do_write(2, 12'h094, 32'hA5A5_5A5A, 0, 0);
        do_read(12'h094, 32'hA5A5_5A5A, 0, "R11 fresh coefficient");
        do_write(1, 12'h0BC, 32'h0BAD_F00D, 3, 0);
        do_read(12'h0BC, 32'h0BAD_F00D, 2, "R11 fresh coefficient");
        do_read(12'h090, pat(4), 0, "R11 neighbour intact");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule